// File: doc/BRIEF.md
# UART Receiver with Overrun Discard

This block is the receive half of an asynchronous serial port. It watches one serial input, synchronises it to the system clock, and finds the start of each character in two steps. First the line has to be seen high (idle). Then a falling edge begins a start-bit check. Timing comes from a 16x oversampling tick, which is an input because the baud-rate generator lives outside the block.

Once a start bit is confirmed, the block samples each data bit near its centre and shifts it in least significant bit first. It then checks an optional parity bit and a single stop bit. A finished character goes into a one-entry holding register, and a one-cycle completion pulse is raised.

If software has not read the previous character, the new one is thrown away and an overrun flag is set. Parity and framing errors are flagged but never cut a frame short. Software reads the holding register with a read strobe and clears the sticky error flags with a clear strobe.

Top module: `uart_rx_core`

## Requirements
- R1: The receiver is active only while both `pwr_en` and `rx_en` are high. While either is low, the line is ignored, no completion pulse is produced and the holding register does not change.
- R2: After the receiver becomes active, a falling edge is accepted only once the line has been seen high. A line that is already low when the receiver is enabled does not start a frame.
- R3: The start bit is checked on the 8th tick after the falling edge is seen. If the line is high at that point, the receiver drops the attempt and waits again for a falling edge, with no completion pulse.
- R4: The frame is a start bit, then 8 data bits least significant first, then an optional parity bit, then a stop bit. The start-bit check and every later bit sample are 16 ticks apart.
- R5: When the stop bit is sampled, the character is written to `rx_data`, `rx_full` is set, and `done_pulse` is high for exactly one cycle. After reset, `rx_data` is 0 and `rx_full`, `done_pulse` and all error flags are low.
- R6: If `rx_full` is still set when a new character completes, `err_overrun` is set. The new character is discarded, `rx_data` keeps the old value, and `done_pulse` is still produced.
- R7: `par_mode` selects the parity bit: 2'b00 means none, 2'b01 means even (the data bits and parity bit together hold an even number of ones), 2'b10 means odd, and 2'b11 is treated as none. A mismatch sets `err_parity`, and the frame still completes and is stored.
- R8: A stop bit sampled low sets `err_frame`. The character is still stored and `done_pulse` is still produced.
- R9: The error flags are sticky. A `clr_err` pulse clears all three flags on the next cycle. If an error is raised in the same cycle as the clear, the flag is set.
- R10: A `rd_stb` pulse clears `rx_full` on the next cycle. A read in the same cycle as a completion counts as done, so the new character is stored.
- R11: Dropping either enable in the middle of a frame aborts it. There is no completion pulse, and `rx_data` and `rx_full` are unchanged.
- R12: Only one stop bit is checked. Any further high bits count as idle line, so a frame with two stop bits followed at once by another frame gives two correct characters with no framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power enable of the receiver |
| rx_en | input | 1 | Receive enable |
| os_tick | input | 1 | 16x oversampling tick, one clock wide |
| rx_pin | input | 1 | Asynchronous serial input, idle high |
| par_mode | input | 2 | Parity select: 00 none, 01 even, 10 odd, 11 none |
| rd_stb | input | 1 | Read strobe for the holding register |
| clr_err | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Holding register |
| rx_full | output | 1 | Holding register holds an unread character |
| done_pulse | output | 1 | One-cycle completion pulse |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
A level on `rx_pin` reaches the frame sequencer after two synchroniser clocks. The stop-bit sample falls 8 ticks plus a few clocks into the stop bit. The commit register and the holding stage each add one clock, so `done_pulse`, `rx_data` and the error flags settle well before the stop bit ends. Each check therefore waits until at least one idle bit time after the stop bit, and a posedge monitor counts completion pulses so that the bench does not depend on catching the exact cycle. `rx_full` and the error flags are due one clock after `rd_stb` or `clr_err`, and they are sampled at the following falling edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SEEK_HI,
    ST_WAIT_FALL,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic par_err;
    logic frm_err;
  } frame_err_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic line
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q[0] <= 1'b1;
          else     q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q[i] <= 1'b1;
          else     q[i] <= q[i-1];
        end
      end
    end
  endgenerate

  assign line = q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        par_mode,
  output logic              commit,
  output logic [DATA_W-1:0] char_out,
  output frame_err_t        errs
);
  localparam int CNT_W = $clog2(OVS);
  localparam int MID   = OVS / 2;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] IDX_LAST = BIT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] sh;
  logic              par_bad;
  logic              has_par;
  logic              odd_sel;

  assign has_par = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
  assign odd_sel = (par_mode == PAR_ODD);

  always_ff @(posedge clk) begin
    commit <= 1'b0;
    if (rst) begin
      state    <= ST_OFF;
      cnt      <= '0;
      bit_idx  <= '0;
      sh       <= '0;
      par_bad  <= 1'b0;
      char_out <= '0;
      errs     <= '0;
    end else if (!active) begin
      state <= ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:       state <= ST_SEEK_HI;
        ST_SEEK_HI:   if (line) state <= ST_WAIT_FALL;
        ST_WAIT_FALL: if (!line) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: if (tick) begin
          if (cnt == MID_LAST) begin
            cnt     <= '0;
            bit_idx <= '0;
            par_bad <= 1'b0;
            state   <= line ? ST_SEEK_HI : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          if (cnt == BIT_LAST) begin
            cnt <= '0;
            sh  <= {line, sh[DATA_W-1:1]};
            if (bit_idx == IDX_LAST) state <= has_par ? ST_PARITY : ST_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PARITY: if (tick) begin
          if (cnt == BIT_LAST) begin
            cnt     <= '0;
            par_bad <= line ^ (^sh) ^ odd_sel;
            state   <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: if (tick) begin
          if (cnt == BIT_LAST) begin
            cnt           <= '0;
            commit        <= 1'b1;
            char_out      <= sh;
            errs.par_err  <= par_bad;
            errs.frm_err  <= ~line;
            state         <= ST_SEEK_HI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [DATA_W-1:0] char_in,
  input  frame_err_t        errs,
  input  logic              rd_stb,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              done_pulse,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic still_full;
  assign still_full = rx_full && !rd_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      done_pulse  <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      done_pulse <= commit;
      if (commit && !still_full) begin
        rx_data <= char_in;
        rx_full <= 1'b1;
      end else if (rd_stb) begin
        rx_full <= 1'b0;
      end
      if (clr_err) begin
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (commit && errs.par_err) err_parity  <= 1'b1;
      if (commit && errs.frm_err) err_frame   <= 1'b1;
      if (commit && still_full)   err_overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_en,
  input  logic              rx_en,
  input  logic              os_tick,
  input  logic              rx_pin,
  input  logic [1:0]        par_mode,
  input  logic              rd_stb,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              done_pulse,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic              line_s;
  logic              active;
  logic              frame_commit;
  logic [DATA_W-1:0] frame_char;
  frame_err_t        frame_errs;

  assign active = pwr_en & rx_en;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(rx_pin), .line(line_s)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst(rst), .active(active), .tick(os_tick), .line(line_s),
    .par_mode(par_mode), .commit(frame_commit), .char_out(frame_char),
    .errs(frame_errs)
  );

  rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .commit(frame_commit), .char_in(frame_char),
    .errs(frame_errs), .rd_stb(rd_stb), .clr_err(clr_err),
    .rx_data(rx_data), .rx_full(rx_full), .done_pulse(done_pulse),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_en,
  input logic              rx_en,
  input logic              rd_stb,
  input logic              clr_err,
  input logic              commit,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              done_pulse,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_overrun
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    $past(!(pwr_en && rx_en), 2) |-> !done_pulse);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  a_r5_full_with_done: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> rx_full);

  a_r6_keep_old_data: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $stable(rx_data));

  a_r9_clear_flags: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !commit) |=> (!err_parity && !err_frame && !err_overrun));

  a_r9_frame_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_frame && !clr_err) |=> err_frame);

  a_r10_read_empties: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !commit) |=> !rx_full);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_en(pwr_en), .rx_en(rx_en), .rd_stb(rd_stb),
  .clr_err(clr_err), .commit(frame_commit), .rx_data(rx_data),
  .rx_full(rx_full), .done_pulse(done_pulse), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_en = 1'b0, rx_en = 1'b0, os_tick = 1'b0, rx_pin = 1'b1;
  logic [1:0] par_mode = 2'b00;
  logic       rd_stb = 1'b0, clr_err = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, done_pulse, err_parity, err_frame, err_overrun;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int div_cnt = 0;
  bit finished = 1'b0;

  uart_rx_core uut (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .rx_en(rx_en), .os_tick(os_tick),
    .rx_pin(rx_pin), .par_mode(par_mode), .rd_stb(rd_stb), .clr_err(clr_err),
    .rx_data(rx_data), .rx_full(rx_full), .done_pulse(done_pulse),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    os_tick <= (div_cnt == TICK_DIV - 1);
    div_cnt <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
  end

  always @(posedge clk) if (!rst && done_pulse) done_cnt <= done_cnt + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(logic b);
    rx_pin = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // mode: 0 none, 1 even, 2 odd; bad_par flips the parity bit
  task automatic send_frame(logic [7:0] d, int mode, bit bad_par,
                            logic stop_v, int idle_bits);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (mode == 1 || mode == 2) hold_bit((^d) ^ (mode == 2) ^ bad_par);
    hold_bit(stop_v);
    for (int i = 0; i < idle_bits; i++) hold_bit(1'b1);
  endtask

  task automatic pulse_read();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk) clr_err = 1'b1;
    @(negedge clk) clr_err = 1'b0;
  endtask

  task automatic t_reset();
    check("R5 reset data", rx_data, 0);
    check("R5 reset full", rx_full, 0);
    check("R5 reset done", done_cnt, 0);
    check("R9 reset flags", {err_parity, err_frame, err_overrun}, 0);
  endtask

  task automatic t_disabled();
    int d0 = done_cnt;
    pwr_en = 1'b0; rx_en = 1'b1;
    send_frame(8'h6E, 0, 0, 1'b1, 2);
    pwr_en = 1'b1; rx_en = 1'b0;
    send_frame(8'h6E, 0, 0, 1'b1, 2);
    check("R1 no done while off", done_cnt, d0);
    check("R1 holding untouched", rx_full, 0);
  endtask

  task automatic t_basic();
    int d0;
    pwr_en = 1'b1; rx_en = 1'b1;
    hold_bit(1'b1);
    d0 = done_cnt;
    send_frame(8'hA5, 0, 0, 1'b1, 1);
    check("R5 done count", done_cnt, d0 + 1);
    check("R4 data A5", rx_data, 8'hA5);
    check("R5 full set", rx_full, 1);
    check("R4 no errors", {err_parity, err_frame, err_overrun}, 0);
    pulse_read();
    check("R10 read clears full", rx_full, 0);
    send_frame(8'h3C, 0, 0, 1'b1, 1);
    check("R4 data 3C", rx_data, 8'h3C);
    pulse_read();
  endtask

  task automatic t_glitch();
    int d0 = done_cnt;
    rx_pin = 1'b0;
    repeat (6) @(negedge clk);
    rx_pin = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R3 glitch ignored", done_cnt, d0);
    send_frame(8'h81, 0, 0, 1'b1, 1);
    check("R3 frame after glitch", rx_data, 8'h81);
    check("R3 one completion", done_cnt, d0 + 1);
    pulse_read();
  endtask

  task automatic t_seek_high();
    int d0;
    rx_en = 1'b0;
    rx_pin = 1'b0;
    hold_bit(1'b0);
    d0 = done_cnt;
    rx_en = 1'b1;
    repeat (12) hold_bit(1'b0);
    repeat (2) hold_bit(1'b1);
    send_frame(8'h5A, 0, 0, 1'b1, 1);
    check("R2 no frame from low line", done_cnt, d0 + 1);
    check("R2 data after idle", rx_data, 8'h5A);
    pulse_read();
  endtask

  task automatic t_overrun();
    int d0 = done_cnt;
    send_frame(8'h11, 0, 0, 1'b1, 1);
    send_frame(8'h22, 0, 0, 1'b1, 1);
    check("R6 done still pulses", done_cnt, d0 + 2);
    check("R6 overrun flag", err_overrun, 1);
    check("R6 old data kept", rx_data, 8'h11);
    pulse_read();
  endtask

  task automatic t_clear();
    repeat (5) @(negedge clk);
    check("R9 flag sticky", err_overrun, 1);
    pulse_clear();
    check("R9 flags cleared", {err_parity, err_frame, err_overrun}, 0);
  endtask

  task automatic t_parity();
    int d0 = done_cnt;
    par_mode = 2'b01;
    send_frame(8'h37, 1, 0, 1'b1, 1);
    check("R7 even ok", err_parity, 0);
    check("R7 even data", rx_data, 8'h37);
    pulse_read();
    par_mode = 2'b10;
    send_frame(8'h37, 2, 0, 1'b1, 1);
    check("R7 odd ok", err_parity, 0);
    pulse_read();
    par_mode = 2'b01;
    send_frame(8'hC4, 1, 1, 1'b1, 1);
    check("R7 parity error", err_parity, 1);
    check("R7 stored anyway", rx_data, 8'hC4);
    check("R7 completions", done_cnt, d0 + 3);
    pulse_read();
    pulse_clear();
    par_mode = 2'b00;
  endtask

  task automatic t_framing();
    int d0 = done_cnt;
    send_frame(8'h9D, 0, 0, 1'b0, 2);
    check("R8 framing flag", err_frame, 1);
    check("R8 data stored", rx_data, 8'h9D);
    check("R8 done pulse", done_cnt, d0 + 1);
    pulse_read();
    pulse_clear();
  endtask

  task automatic t_abort();
    int d0 = done_cnt;
    logic [7:0] d = 8'hE7;
    hold_bit(1'b0);
    for (int i = 0; i < 4; i++) hold_bit(d[i]);
    rx_en = 1'b0;
    for (int i = 4; i < 8; i++) hold_bit(d[i]);
    hold_bit(1'b1);
    hold_bit(1'b1);
    rx_en = 1'b1;
    hold_bit(1'b1);
    check("R11 no done on abort", done_cnt, d0);
    check("R11 full unchanged", rx_full, 0);
    check("R11 data unchanged", rx_data, 8'h9D);
  endtask

  task automatic t_two_stop();
    int d0 = done_cnt;
    send_frame(8'h4B, 0, 0, 1'b1, 1);
    check("R12 first char", rx_data, 8'h4B);
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    send_frame(8'hB2, 0, 0, 1'b1, 1);
    check("R12 second char", rx_data, 8'hB2);
    check("R12 both done", done_cnt, d0 + 2);
    check("R12 no framing error", err_frame, 0);
    pulse_read();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_glitch();
    t_seek_high();
    t_overrun();
    t_clear();
    t_parity();
    t_framing();
    t_abort();
    t_two_stop();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule